// File: doc/BRIEF.md
# MAC Address Lookup Engine

The block holds a small table of address entries for a three-port switch and answers forwarding questions about it. Each entry is 69 bits wide and sits behind three 32-bit data words. Software fills and inspects the table through an indirect register window: it stages an entry in the data words and commits it to an index, or it loads an index back into the data words.

A lookup request carries a 48-bit destination MAC and the ingress port. The engine walks the table one entry per cycle, lowest index first. Only entries typed as address or as VLAN-plus-address take part. An exact MAC match gives a port mask: a single bit for unicast, the stored mask for multicast. A miss floods to every forwarding port except the ingress port. The result is then limited to ports in the forwarding state.

A global control register holds the engine enable and a self-clearing table-clear trigger. The table is also wiped automatically after reset. Per-port control registers hold a two-bit port state.

Top module: `mac_lookup_engine`

## Requirements
- R1: After reset, the control register (address 0) reads with enable bit 31 at 0. Every port control register (address 5 + port) reads 0. The VLAN-mode bit 2 reads 0. The response outputs are low.
- R2: A write to the table-control register (address 1) with bit 31 set stores the staged entry at the index in its low bits. The staged entry is made of data word 0 (address 2) bits 4:0 as entry bits 68:64, data word 1 (address 3) as bits 63:32, and data word 2 (address 4) as bits 31:0.
- R3: A write to address 1 with bit 31 clear copies the entry at that index into the three data words, with the same bit layout. Word 0 bits 31:5 read as 0 after the copy.
- R4: Only entries whose type field (bits 61:60) is 1 (address) or 3 (VLAN plus address) can match. A match requires all 48 bits 47:0 to equal the requested MAC, with the first address byte in bits 47:40.
- R5: On a unicast hit (entry bit 40 clear), the mask has only the bit of the port number in bits 67:66. A port number of 3 or above gives an empty mask, and the response still reports a hit.
- R6: On a multicast hit (entry bit 40 set), the mask is taken from entry bits 68:66, one bit per port.
- R7: Any port whose state is not forwarding (value 3) is dropped from every response mask. The other state values are 0 disabled, 1 blocking and 2 learning.
- R8: A request whose ingress port is not in the forwarding state, or is not a port at all, answers with an empty mask and hit low.
- R9: A request that matches no entry answers with hit low and a mask of all forwarding ports minus the ingress port.
- R10: While the enable bit is 0, the table is not searched and every request is answered as a miss.
- R11: Writing bit 30 of the control register clears every entry to type free. The same clear runs automatically after reset. Bit 30 reads 1 until the clear has finished and then drops by itself. No request is accepted while the clear runs.
- R12: When several entries match, the one with the lowest index decides the answer.
- R13: Each accepted request produces exactly one response, and rsp_valid is high for a single cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe; data appears on reg_rdata one cycle later |
| reg_addr | input | 4 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Registered read data |
| lk_valid | input | 1 | Lookup request valid |
| lk_ready | output | 1 | Engine can take a request this cycle |
| lk_mac | input | 48 | Destination MAC to look up |
| lk_port | input | 2 | Ingress port number |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_hit | output | 1 | A table entry matched |
| rsp_mask | output | 3 | Forwarding port mask |

## Verification
The assertions assume that port states do not change in the cycle a response is formed. The forwarding check compares each mask with the port states one cycle earlier, so this assumption is what lets that comparison hold. They also assume that lk_port is stable in the accepting cycle, because the flood check relies on the latched ingress port. The stimulus changes port registers and the enable only between lookups, after each response has been seen. It drives requests and register writes on the falling clock edge. It never writes table entries while a scan is running, so each answer reflects one consistent table.

// File: rtl/mle_pkg.sv
package mle_pkg;
  localparam int unsigned ENT_W     = 69;
  localparam int unsigned MAC_W     = 48;
  localparam int unsigned PNUM_W    = 2;
  localparam int unsigned MAX_PORTS = 3;

  typedef enum logic [1:0] {
    ET_FREE  = 2'd0,
    ET_ADDR  = 2'd1,
    ET_VLAN  = 2'd2,
    ET_VADDR = 2'd3
  } ent_type_e;

  typedef enum logic [1:0] {
    PS_OFF   = 2'd0,
    PS_BLOCK = 2'd1,
    PS_LEARN = 2'd2,
    PS_FWD   = 2'd3
  } port_state_e;

  // entry carries an address and so may take part in a match
  function automatic logic ent_has_addr(input logic [ENT_W-1:0] e);
    return (e[61:60] == ET_ADDR) || (e[61:60] == ET_VADDR);
  endfunction

  function automatic logic [MAC_W-1:0] ent_mac(input logic [ENT_W-1:0] e);
    return e[47:0];
  endfunction

  function automatic logic ent_mcast(input logic [ENT_W-1:0] e);
    return e[40];
  endfunction

  function automatic logic [PNUM_W-1:0] ent_port(input logic [ENT_W-1:0] e);
    return e[67:66];
  endfunction

  function automatic logic [MAX_PORTS-1:0] ent_pmask(input logic [ENT_W-1:0] e);
    return e[68:66];
  endfunction
endpackage

// File: rtl/mle_table.sv
module mle_table #(
  parameter int unsigned ENTRIES = 16,
  parameter int unsigned WIDTH   = 69,
  localparam int unsigned IDX_W  = $clog2(ENTRIES)
) (
  input  logic             clk,
  input  logic             we,
  input  logic [IDX_W-1:0] waddr,
  input  logic [WIDTH-1:0] wdata,
  input  logic [IDX_W-1:0] raddr,
  output logic [WIDTH-1:0] rdata
);
  logic [WIDTH-1:0] mem [ENTRIES];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/mle_regs.sv
module mle_regs
  import mle_pkg::*;
#(
  parameter int unsigned ENTRIES = 16,
  parameter int unsigned NPORTS  = 3,
  parameter int unsigned REG_AW  = 4,
  localparam int unsigned IDX_W  = $clog2(ENTRIES)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic [ENT_W-1:0]  mem_q,
  output logic              enable,
  output logic [NPORTS-1:0] fwd_mask,
  output logic              clr_busy,
  output logic              tbl_we,
  output logic [IDX_W-1:0]  tbl_waddr,
  output logic [ENT_W-1:0]  tbl_wdata,
  output logic              ld_req,
  output logic [IDX_W-1:0]  ld_idx
);
  localparam logic [REG_AW-1:0] A_CTRL  = REG_AW'(0);
  localparam logic [REG_AW-1:0] A_TCTL  = REG_AW'(1);
  localparam logic [REG_AW-1:0] A_DW0   = REG_AW'(2);
  localparam logic [REG_AW-1:0] A_PORT0 = REG_AW'(5);
  localparam logic [IDX_W-1:0]  LAST    = IDX_W'(ENTRIES - 1);
  localparam int unsigned       TOP_W   = ENT_W - 64;

  logic [31:0]      dw [3];
  logic             vlan_q;
  logic [IDX_W-1:0] tidx_q;
  logic [IDX_W-1:0] clr_idx;
  logic             ld_pend;
  logic [1:0]       pst [NPORTS];
  logic             sel_tctl;
  logic             commit;
  logic [31:0]      rd_mux;

  assign sel_tctl  = reg_wr && (reg_addr == A_TCTL);
  assign commit    = sel_tctl && reg_wdata[31] && !clr_busy;
  assign ld_req    = sel_tctl && !reg_wdata[31];
  assign ld_idx    = reg_wdata[IDX_W-1:0];
  assign tbl_we    = clr_busy || commit;
  assign tbl_waddr = clr_busy ? clr_idx : reg_wdata[IDX_W-1:0];
  assign tbl_wdata = clr_busy ? '0 : {dw[0][TOP_W-1:0], dw[1], dw[2]};

  always_ff @(posedge clk) begin
    if (rst) begin
      enable   <= 1'b0;
      vlan_q   <= 1'b0;
      tidx_q   <= '0;
      clr_busy <= 1'b1;
      clr_idx  <= '0;
      ld_pend  <= 1'b0;
      for (int w = 0; w < 3; w++) dw[w] <= '0;
    end else begin
      ld_pend <= ld_req;
      if (clr_busy) begin
        clr_idx <= clr_idx + 1'b1;
        if (clr_idx == LAST) clr_busy <= 1'b0;
      end
      if (reg_wr) begin
        if (reg_addr == A_CTRL) begin
          enable <= reg_wdata[31];
          vlan_q <= reg_wdata[2];
          if (reg_wdata[30] && !clr_busy) begin
            clr_busy <= 1'b1;
            clr_idx  <= '0;
          end
        end
        if (reg_addr == A_TCTL) tidx_q <= reg_wdata[IDX_W-1:0];
        for (int w = 0; w < 3; w++)
          if (reg_addr == A_DW0 + REG_AW'(w)) dw[w] <= reg_wdata;
      end
      if (ld_pend) begin
        dw[0] <= 32'(mem_q[ENT_W-1:64]);
        dw[1] <= mem_q[63:32];
        dw[2] <= mem_q[31:0];
      end
    end
  end

  for (genvar p = 0; p < NPORTS; p++) begin : g_port
    logic [1:0] st_q;
    always_ff @(posedge clk) begin
      if (rst) st_q <= PS_OFF;
      else if (reg_wr && reg_addr == A_PORT0 + REG_AW'(p)) st_q <= reg_wdata[1:0];
    end
    assign pst[p]      = st_q;
    assign fwd_mask[p] = (st_q == PS_FWD);
  end

  always_comb begin
    rd_mux = '0;
    if (reg_addr == A_CTRL) rd_mux = {enable, clr_busy, 27'b0, vlan_q, 2'b0};
    if (reg_addr == A_TCTL) rd_mux = 32'(tidx_q);
    for (int w = 0; w < 3; w++)
      if (reg_addr == A_DW0 + REG_AW'(w)) rd_mux = dw[w];
    for (int p = 0; p < NPORTS; p++)
      if (reg_addr == A_PORT0 + REG_AW'(p)) rd_mux = {30'b0, pst[p]};
  end

  always_ff @(posedge clk) begin
    if (rst) reg_rdata <= '0;
    else if (reg_rd) reg_rdata <= rd_mux;
  end

  // R11: the clear walk ends right after the last index has been written
  a_r11_clear_ends: assert property (@(posedge clk) disable iff (rst)
    (clr_busy && clr_idx == LAST) |=> !clr_busy);
endmodule

// File: rtl/mle_search.sv
module mle_search
  import mle_pkg::*;
#(
  parameter int unsigned ENTRIES = 16,
  parameter int unsigned NPORTS  = 3,
  localparam int unsigned IDX_W  = $clog2(ENTRIES)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              enable,
  input  logic [NPORTS-1:0] fwd_mask,
  input  logic              clr_busy,
  input  logic              ld_req,
  input  logic [ENT_W-1:0]  mem_q,
  output logic [IDX_W-1:0]  scan_idx,
  input  logic              lk_valid,
  output logic              lk_ready,
  input  logic [MAC_W-1:0]  lk_mac,
  input  logic [PNUM_W-1:0] lk_port,
  output logic              rsp_valid,
  output logic              rsp_hit,
  output logic [NPORTS-1:0] rsp_mask
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(ENTRIES - 1);

  typedef enum logic {S_IDLE, S_SCAN} st_e;

  st_e               state;
  logic [IDX_W-1:0]  iss_idx, chk_idx;
  logic              iss_done, chk_v;
  logic [MAC_W-1:0]  mac_q;
  logic [PNUM_W-1:0] port_q;
  logic              accept, in_fwd, scan_issue, hit_now;
  logic [NPORTS-1:0] hit_mask;

  function automatic logic [NPORTS-1:0] port_bit(input logic [PNUM_W-1:0] p);
    for (int i = 0; i < NPORTS; i++) port_bit[i] = (p == PNUM_W'(i));
  endfunction

  assign lk_ready   = (state == S_IDLE) && !rsp_valid && !clr_busy;
  assign accept     = lk_valid && lk_ready;
  assign in_fwd     = |(port_bit(lk_port) & fwd_mask);
  assign scan_issue = (state == S_SCAN) && !iss_done && !ld_req;
  assign scan_idx   = iss_idx;
  assign hit_now    = chk_v && ent_has_addr(mem_q) && (ent_mac(mem_q) == mac_q);
  assign hit_mask   = ent_mcast(mem_q) ? ent_pmask(mem_q)[NPORTS-1:0]
                                       : port_bit(ent_port(mem_q));

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= S_IDLE;
      iss_idx   <= '0;
      iss_done  <= 1'b0;
      chk_v     <= 1'b0;
      chk_idx   <= '0;
      mac_q     <= '0;
      port_q    <= '0;
      rsp_valid <= 1'b0;
      rsp_hit   <= 1'b0;
      rsp_mask  <= '0;
    end else begin
      rsp_valid <= 1'b0;
      case (state)
        S_IDLE: if (accept) begin
          mac_q  <= lk_mac;
          port_q <= lk_port;
          if (!enable || !in_fwd) begin
            rsp_valid <= 1'b1;
            rsp_hit   <= 1'b0;
            rsp_mask  <= in_fwd ? (fwd_mask & ~port_bit(lk_port)) : '0;
          end else begin
            state    <= S_SCAN;
            iss_idx  <= '0;
            iss_done <= 1'b0;
            chk_v    <= 1'b0;
          end
        end
        S_SCAN: begin
          chk_v   <= scan_issue;
          chk_idx <= iss_idx;
          if (scan_issue) begin
            iss_idx <= iss_idx + 1'b1;
            if (iss_idx == LAST) iss_done <= 1'b1;
          end
          if (hit_now) begin
            rsp_valid <= 1'b1;
            rsp_hit   <= 1'b1;
            rsp_mask  <= hit_mask & fwd_mask;
            state     <= S_IDLE;
            chk_v     <= 1'b0;
          end else if (chk_v && chk_idx == LAST) begin
            rsp_valid <= 1'b1;
            rsp_hit   <= 1'b0;
            rsp_mask  <= fwd_mask & ~port_bit(port_q);
            state     <= S_IDLE;
            chk_v     <= 1'b0;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  // R7: no response names a port that was not forwarding when it was formed
  a_r7_fwd_only: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> ((rsp_mask & ~$past(fwd_mask)) == '0));

  // R9: a flooded answer never goes back out of the ingress port
  a_r9_no_ingress: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && !rsp_hit) |-> ((rsp_mask & port_bit(port_q)) == '0));

  // R13: the response strobe lasts one cycle
  a_r13_pulse: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |=> !rsp_valid);

  // R11: no scan starts while the table is being wiped
  a_r11_no_scan_in_clear: assert property (@(posedge clk) disable iff (rst)
    (state == S_IDLE && lk_valid && clr_busy) |=> (state == S_IDLE));
endmodule

// File: rtl/mac_lookup_engine.sv
module mac_lookup_engine
  import mle_pkg::*;
#(
  parameter int unsigned ENTRIES = 16,
  parameter int unsigned NPORTS  = 3,
  parameter int unsigned REG_AW  = 4,
  localparam int unsigned IDX_W  = $clog2(ENTRIES)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic              lk_valid,
  output logic              lk_ready,
  input  logic [MAC_W-1:0]  lk_mac,
  input  logic [PNUM_W-1:0] lk_port,
  output logic              rsp_valid,
  output logic              rsp_hit,
  output logic [NPORTS-1:0] rsp_mask
);
  logic              enable, clr_busy, tbl_we, ld_req;
  logic [NPORTS-1:0] fwd_mask;
  logic [IDX_W-1:0]  tbl_waddr, ld_idx, scan_idx, rd_addr;
  logic [ENT_W-1:0]  tbl_wdata, mem_q;

  // table loads from the register side take the read port over the scan
  assign rd_addr = ld_req ? ld_idx : scan_idx;

  mle_table #(.ENTRIES(ENTRIES), .WIDTH(ENT_W)) u_table (
    .clk(clk), .we(tbl_we), .waddr(tbl_waddr), .wdata(tbl_wdata),
    .raddr(rd_addr), .rdata(mem_q)
  );

  mle_regs #(.ENTRIES(ENTRIES), .NPORTS(NPORTS), .REG_AW(REG_AW)) u_regs (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .mem_q(mem_q), .enable(enable), .fwd_mask(fwd_mask), .clr_busy(clr_busy),
    .tbl_we(tbl_we), .tbl_waddr(tbl_waddr), .tbl_wdata(tbl_wdata),
    .ld_req(ld_req), .ld_idx(ld_idx)
  );

  mle_search #(.ENTRIES(ENTRIES), .NPORTS(NPORTS)) u_search (
    .clk(clk), .rst(rst), .enable(enable), .fwd_mask(fwd_mask),
    .clr_busy(clr_busy), .ld_req(ld_req), .mem_q(mem_q), .scan_idx(scan_idx),
    .lk_valid(lk_valid), .lk_ready(lk_ready), .lk_mac(lk_mac),
    .lk_port(lk_port), .rsp_valid(rsp_valid), .rsp_hit(rsp_hit),
    .rsp_mask(rsp_mask)
  );
endmodule

// File: tb/mac_lookup_engine_bench.sv
`timescale 1ns/1ps
module mac_lookup_engine_bench;
  localparam real HALF = 2.5;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [3:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        lk_valid = 1'b0, lk_ready;
  logic [47:0] lk_mac = '0;
  logic [1:0]  lk_port = '0;
  logic        rsp_valid, rsp_hit;
  logic [2:0]  rsp_mask;

  int total = 0;
  int bad   = 0;

  always #(HALF) clk = ~clk;

  mac_lookup_engine u_mac_lookup_engine (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .lk_valid(lk_valid), .lk_ready(lk_ready), .lk_mac(lk_mac),
    .lk_port(lk_port), .rsp_valid(rsp_valid), .rsp_hit(rsp_hit),
    .rsp_mask(rsp_mask)
  );

  // {mac, ingress, expected hit, expected mask}; all ports forwarding
  localparam logic [53:0] VECS [0:8] = '{
    {48'h02_00_00_00_00_01, 2'd0, 1'b1, 3'b010}, // R5 R12: idx0 beats idx4
    {48'h01_00_5E_00_00_05, 2'd1, 1'b1, 3'b101}, // R6 multicast mask
    {48'h02_00_00_00_00_07, 2'd0, 1'b0, 3'b110}, // R4 VLAN-only type ignored
    {48'h02_00_00_00_00_08, 2'd1, 1'b1, 3'b100}, // R4 VLAN+address type matches
    {48'h02_00_00_00_00_09, 2'd2, 1'b1, 3'b000}, // R5 port number 3
    {48'h02_00_00_00_00_99, 2'd2, 1'b0, 3'b011}, // R9 flood
    {48'hFF_FF_FF_FF_FF_FF, 2'd0, 1'b1, 3'b111}, // R6 broadcast
    {48'h02_00_00_00_00_0A, 2'd1, 1'b1, 3'b001}, // R4 last index
    {48'h03_00_00_00_00_01, 2'd1, 1'b0, 3'b101}  // R4 first byte differs
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic reg_write(input logic [3:0] a, input logic [31:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic reg_read(input logic [3:0] a, output logic [31:0] d);
    reg_rd = 1'b1; reg_addr = a;
    @(negedge clk);
    reg_rd = 1'b0;
    d = reg_rdata;
  endtask

  function automatic logic [68:0] mk_uc(input logic [47:0] mac, input logic [1:0] p,
                                       input logic [1:0] typ);
    logic [68:0] e = '0;
    e[61:60] = typ; e[47:0] = mac; e[67:66] = p;
    return e;
  endfunction

  function automatic logic [68:0] mk_mc(input logic [47:0] mac, input logic [2:0] m);
    logic [68:0] e = '0;
    e[61:60] = 2'd1; e[63:62] = 2'd3; e[47:0] = mac; e[68:66] = m;
    return e;
  endfunction

  task automatic tbl_write(input int idx, input logic [68:0] e);
    reg_write(4'd2, 32'(e[68:64]));
    reg_write(4'd3, e[63:32]);
    reg_write(4'd4, e[31:0]);
    reg_write(4'd1, 32'h8000_0000 | 32'(idx));
  endtask

  task automatic lookup(input logic [47:0] mac, input logic [1:0] p,
                        output logic hit, output logic [2:0] mask);
    bit got = 0;
    lk_valid = 1'b1; lk_mac = mac; lk_port = p;
    for (int k = 0; k < 100 && !lk_ready; k++) @(negedge clk);
    @(negedge clk);
    lk_valid = 1'b0;
    for (int k = 0; k < 100; k++) begin
      if (rsp_valid) begin got = 1; break; end
      @(negedge clk);
    end
    hit = rsp_hit; mask = rsp_mask;
    chk("R13 response seen", 32'(got), 32'd1);
    @(negedge clk);
    chk("R13 single-cycle strobe", 32'(rsp_valid), 32'd0);
  endtask

  initial begin
    #(HALF * 2 * 100000);
    bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] d;
    logic        h;
    logic [2:0]  m;
    logic [68:0] e;

    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    chk("R1 rsp_valid low after reset", 32'(rsp_valid), 32'd0);
    chk("R11 not ready while clearing", 32'(lk_ready), 32'd0);
    reg_read(4'd0, d);
    chk("R11 clear bit set after reset", d, 32'h4000_0000);
    repeat (20) @(negedge clk);
    reg_read(4'd0, d);
    chk("R1 control reset value", d, 32'h0);
    reg_read(4'd6, d);
    chk("R1 port control reset value", d, 32'h0);

    reg_write(4'd0, 32'h8000_0000);
    for (int p = 0; p < 3; p++) reg_write(4'(5 + p), 32'd3);

    tbl_write(0,  mk_uc(48'h02_00_00_00_00_01, 2'd1, 2'd1));
    tbl_write(1,  mk_mc(48'h01_00_5E_00_00_05, 3'b101));
    tbl_write(2,  mk_uc(48'h02_00_00_00_00_07, 2'd0, 2'd2));
    tbl_write(3,  mk_uc(48'h02_00_00_00_00_08, 2'd2, 2'd3));
    tbl_write(4,  mk_uc(48'h02_00_00_00_00_01, 2'd0, 2'd1));
    tbl_write(5,  mk_uc(48'h02_00_00_00_00_09, 2'd3, 2'd1));
    tbl_write(6,  mk_mc(48'hFF_FF_FF_FF_FF_FF, 3'b111));
    tbl_write(15, mk_uc(48'h02_00_00_00_00_0A, 2'd0, 2'd1));

    for (int v = 0; v < 9; v++) begin
      lookup(VECS[v][53:6], VECS[v][5:4], h, m);
      chk($sformatf("vector %0d hit", v), 32'(h), 32'(VECS[v][3]));
      chk($sformatf("vector %0d mask", v), 32'(m), 32'(VECS[v][2:0]));
    end

    // R2 R3: read entry 1 back through the data words
    e = mk_mc(48'h01_00_5E_00_00_05, 3'b101);
    reg_write(4'd2, 32'hFFFF_FFFF);
    reg_write(4'd1, 32'd1);
    repeat (2) @(negedge clk);
    reg_read(4'd2, d); chk("R3 word0 readback", d, 32'(e[68:64]));
    reg_read(4'd3, d); chk("R2 word1 readback", d, e[63:32]);
    reg_read(4'd4, d); chk("R2 word2 readback", d, e[31:0]);

    // R7: port 2 learning only
    reg_write(4'd7, 32'd2);
    reg_read(4'd7, d); chk("R7 port state readback", d, 32'd2);
    lookup(48'hFF_FF_FF_FF_FF_FF, 2'd0, h, m);
    chk("R7 multicast filtered", 32'(m), 32'b011);
    lookup(48'h02_00_00_00_00_99, 2'd0, h, m);
    chk("R7 flood filtered", 32'(m), 32'b010);

    // R8: ingress blocked, or not a port
    reg_write(4'd6, 32'd1);
    lookup(48'h02_00_00_00_00_01, 2'd1, h, m);
    chk("R8 blocked ingress hit", 32'(h), 32'd0);
    chk("R8 blocked ingress mask", 32'(m), 32'd0);
    lookup(48'h02_00_00_00_00_01, 2'd3, h, m);
    chk("R8 ingress 3 mask", 32'(m), 32'd0);
    reg_write(4'd6, 32'd3);
    reg_write(4'd7, 32'd3);

    // R10: engine disabled
    reg_write(4'd0, 32'h0);
    lookup(48'h02_00_00_00_00_01, 2'd0, h, m);
    chk("R10 disabled hit", 32'(h), 32'd0);
    chk("R10 disabled mask", 32'(m), 32'b110);
    reg_write(4'd0, 32'h8000_0000);

    // R11: software clear
    reg_write(4'd0, 32'hC000_0000);
    reg_read(4'd0, d); chk("R11 clear bit while running", d, 32'hC000_0000);
    repeat (20) @(negedge clk);
    reg_read(4'd0, d); chk("R11 clear bit self-clears", d, 32'h8000_0000);
    lookup(48'h02_00_00_00_00_01, 2'd0, h, m);
    chk("R11 cleared table misses", 32'(h), 32'd0);
    chk("R11 cleared table floods", 32'(m), 32'b110);
    reg_write(4'd1, 32'd0);
    repeat (2) @(negedge clk);
    reg_read(4'd4, d); chk("R11 entry words zero", d, 32'h0);
    reg_read(4'd3, d); chk("R11 entry type free", d, 32'h0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule